// File: doc/BRIEF.md
# Link Width Power-State Negotiator

This block runs the message handshake that lets two link partners shrink or grow the number of active lanes while the link stays up in its low-power active state. Either partner may start a change. The local side raises a width request. The block turns it into a Request message and then waits for the partner's acknowledge or reject. If neither arrives before a deadline that depends on the line encoding, the attempt is abandoned. Requests from the partner are checked and answered with an acknowledge or a reject on the following clock.

The agreed width is one lane count that applies to both directions. It is only ever a legal, non-zero width. The feature works only when the link runs in flit mode and both sides advertised support during training. When both sides ask at the same moment, the message priority settles the collision, and the port role breaks a tie. Sequencing of lanes at the ordered-set level and the physical coding are handled elsewhere.

Top module: `lwidth_negotiator`

## Requirements
- R1: The feature is enabled only while `cfg_flit_mode`, `cfg_local_support` and `cfg_partner_support` are all 1. While disabled, a partner Request is answered with NAK carrying payload 1. A local request is refused: `done`=1 and `result_ack`=0 one cycle later, no message is sent, and `err_status` is not changed.
- R2: In idle, a valid partner Request is answered on the next cycle with an ACK that echoes its width and priority. `cur_width` takes that width in the same cycle. One `cur_width` serves both directions.
- R3: A valid local request sends a Request (command 1) carrying the requested width and priority, and sets `busy`. A partner ACK then gives `done`=1, `result_ack`=1 and the new `cur_width`. A partner NAK gives `done`=1 and `result_ack`=0 and leaves `cur_width` unchanged.
- R4: Let E be the clock edge that accepts a local request. The wait lasts CYC_PER_US×4 cycles when `cfg_rate_8b10b`=1 and CYC_PER_US cycles otherwise. An answer sampled at edge E+limit is still accepted. With no answer, that edge ends the wait with `done`=1, `result_ack`=0 and `timed_out`=1, and the width is kept.
- R5: A width is legal only if it is a non-zero power of two that is no larger than MAX_LANES. A partner Request with an illegal width gets NAK payload 2. A partner Request equal to `cur_width` gets NAK payload 3. Either case sets `err_status`, and so does a local request of this kind, which is refused without any message. An accepted width change clears `err_status`.
- R6: If a partner Request arrives while the block is waiting, the higher priority wins. On equal priority, the side with `cfg_is_downstream`=1 wins. If the local side wins, it sends NAK payload 4 and keeps waiting. If the partner wins, the local attempt ends with `done`=1 and `result_ack`=0, and the partner Request is answered as in R2 and R5.
- R7: Messages use management type 6 and commands 1=Request, 2=ACK, 3=NAK. A received message with any other type has no effect. An ACK or NAK received in idle has no effect.
- R8: A local request made while `busy` is ignored. If a local request and a partner Request arrive in the same idle cycle, the partner Request is served and the local request is refused with `done`=1 and `result_ack`=0.
- R9: After reset, `cur_width`=MAX_LANES, and `busy`, `tx_valid` and `err_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flit_mode | input | 1 | Link runs in flit mode |
| cfg_local_support | input | 1 | Local side advertised the feature |
| cfg_partner_support | input | 1 | Partner advertised the feature |
| cfg_rate_8b10b | input | 1 | Link uses 8b/10b encoding (longer deadline) |
| cfg_is_downstream | input | 1 | Port role; wins priority ties |
| loc_req_valid | input | 1 | Local width-change request strobe |
| loc_req_width | input | WW | Requested lane count |
| loc_req_prio | input | PRIO_W | Priority of the local request |
| rx_valid | input | 1 | Decoded received message strobe |
| rx_mtype | input | 4 | Received management type |
| rx_cmd | input | 2 | Received command |
| rx_prio | input | PRIO_W | Received priority |
| rx_width | input | WW | Received lane count |
| tx_valid | output | 1 | Message to transmit |
| tx_mtype | output | 4 | Management type to transmit |
| tx_cmd | output | 2 | Command to transmit |
| tx_prio | output | PRIO_W | Priority to transmit |
| tx_width | output | WW | Lane count to transmit |
| tx_payload | output | 8 | Response payload (reason code) |
| cur_width | output | WW | Agreed lane count, both directions |
| busy | output | 1 | Waiting for the partner's answer |
| done | output | 1 | One-cycle pulse: local attempt finished |
| result_ack | output | 1 | With `done`: attempt was acknowledged |
| timed_out | output | 1 | With `done`: attempt ended by deadline |
| err_status | output | 1 | Last width request was illegal or redundant |

## Verification
A wrong state register shows at the ports quickly. A stuck wait keeps `busy` high past the deadline, and a missing return to idle makes the next partner Request go unanswered or be answered with a collision NAK, one cycle after the message. A corrupted pending width shows up in `cur_width` on the cycle after the partner's ACK. A timer that is off by one moves the `timed_out` pulse, or turns an ACK at the last allowed edge into a timeout. The bench samples both sides of that edge.

// File: rtl/lwn_pkg.sv
package lwn_pkg;

  localparam logic [3:0] MTYPE_WIDTH = 4'd6;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_REQ  = 2'd1;
  localparam logic [1:0] CMD_ACK  = 2'd2;
  localparam logic [1:0] CMD_NAK  = 2'd3;

  localparam int unsigned PAYLOAD_W = 8;

  localparam logic [PAYLOAD_W-1:0] RSN_OK    = 8'd0;
  localparam logic [PAYLOAD_W-1:0] RSN_OFF   = 8'd1;
  localparam logic [PAYLOAD_W-1:0] RSN_BADW  = 8'd2;
  localparam logic [PAYLOAD_W-1:0] RSN_SAMEW = 8'd3;
  localparam logic [PAYLOAD_W-1:0] RSN_COLL  = 8'd4;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} lwn_state_e;

  // Answer window in clock cycles for the current encoding.
  function automatic int unsigned deadline_cycles(input logic slow_code,
                                                  input int unsigned cyc_per_us);
    return (slow_code ? 32'd4 : 32'd1) * cyc_per_us;
  endfunction

  // Non-zero power of two not above the lane count.
  function automatic logic width_legal(input logic [15:0] w,
                                       input int unsigned max_lanes);
    return (w != 16'd0) && ((w & (w - 16'd1)) == 16'd0) &&
           (32'(w) <= max_lanes);
  endfunction

  function automatic logic reason_is_error(input logic [PAYLOAD_W-1:0] r);
    return (r == RSN_BADW) || (r == RSN_SAMEW);
  endfunction

endpackage

// File: rtl/lwn_width_check.sv
module lwn_width_check
  import lwn_pkg::*;
#(
  parameter int unsigned MAX_LANES = 16,
  parameter int unsigned WW        = 5
) (
  input  logic                 feat_en,
  input  logic [WW-1:0]        req_w,
  input  logic [WW-1:0]        cur_w,
  output logic                 ok,
  output logic [PAYLOAD_W-1:0] reason
);
  always_comb begin
    if (!feat_en)                              reason = RSN_OFF;
    else if (!width_legal(16'(req_w), MAX_LANES)) reason = RSN_BADW;
    else if (req_w == cur_w)                   reason = RSN_SAMEW;
    else                                       reason = RSN_OK;
  end

  assign ok = (reason == RSN_OK);
endmodule

// File: rtl/lwn_deadline.sv
module lwn_deadline
  import lwn_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic slow_code,
  output logic expire
);
  localparam int unsigned LIM_MAX = 4 * CYC_PER_US;
  localparam int unsigned CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = CW'(deadline_cycles(slow_code, CYC_PER_US));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start || !run)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign expire = run && (cnt_q == lim - CW'(1));
endmodule

// File: rtl/lwn_arbiter.sv
module lwn_arbiter #(
  parameter int unsigned PRIO_W = 2
) (
  input  logic [PRIO_W-1:0] own_prio,
  input  logic [PRIO_W-1:0] peer_prio,
  input  logic              own_downstream,
  output logic              peer_wins
);
  always_comb begin
    if (peer_prio != own_prio) peer_wins = (peer_prio > own_prio);
    else                       peer_wins = !own_downstream;
  end
endmodule

// File: rtl/lwidth_negotiator.sv
module lwidth_negotiator
  import lwn_pkg::*;
#(
  parameter  int unsigned MAX_LANES  = 16,
  parameter  int unsigned CYC_PER_US = 100,
  parameter  int unsigned PRIO_W     = 2,
  localparam int unsigned WW         = $clog2(MAX_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_flit_mode,
  input  logic                 cfg_local_support,
  input  logic                 cfg_partner_support,
  input  logic                 cfg_rate_8b10b,
  input  logic                 cfg_is_downstream,
  input  logic                 loc_req_valid,
  input  logic [WW-1:0]        loc_req_width,
  input  logic [PRIO_W-1:0]    loc_req_prio,
  input  logic                 rx_valid,
  input  logic [3:0]           rx_mtype,
  input  logic [1:0]           rx_cmd,
  input  logic [PRIO_W-1:0]    rx_prio,
  input  logic [WW-1:0]        rx_width,
  output logic                 tx_valid,
  output logic [3:0]           tx_mtype,
  output logic [1:0]           tx_cmd,
  output logic [PRIO_W-1:0]    tx_prio,
  output logic [WW-1:0]        tx_width,
  output logic [PAYLOAD_W-1:0] tx_payload,
  output logic [WW-1:0]        cur_width,
  output logic                 busy,
  output logic                 done,
  output logic                 result_ack,
  output logic                 timed_out,
  output logic                 err_status
);
  lwn_state_e          state_q;
  logic [WW-1:0]       cur_q, pend_w_q;
  logic [PRIO_W-1:0]   pend_p_q;

  // Named internal events
  logic feat_en, rx_ours, rx_is_req, rx_is_ack, rx_is_nak;
  logic loc_ok, rx_ok, start_wait, deadline_hit, peer_wins, answer_now;
  logic [PAYLOAD_W-1:0] loc_reason, rx_reason;

  assign feat_en    = cfg_flit_mode && cfg_local_support && cfg_partner_support;
  assign rx_ours    = rx_valid && (rx_mtype == MTYPE_WIDTH);
  assign rx_is_req  = rx_ours && (rx_cmd == CMD_REQ);
  assign rx_is_ack  = rx_ours && (rx_cmd == CMD_ACK);
  assign rx_is_nak  = rx_ours && (rx_cmd == CMD_NAK);
  assign start_wait = (state_q == ST_IDLE) && !rx_is_req && loc_req_valid && loc_ok;
  assign answer_now = rx_is_req && ((state_q == ST_IDLE) || peer_wins);

  lwn_width_check #(.MAX_LANES(MAX_LANES), .WW(WW)) u_chk_loc (
    .feat_en(feat_en), .req_w(loc_req_width), .cur_w(cur_q),
    .ok(loc_ok), .reason(loc_reason)
  );

  lwn_width_check #(.MAX_LANES(MAX_LANES), .WW(WW)) u_chk_rx (
    .feat_en(feat_en), .req_w(rx_width), .cur_w(cur_q),
    .ok(rx_ok), .reason(rx_reason)
  );

  lwn_deadline #(.CYC_PER_US(CYC_PER_US)) u_deadline (
    .clk(clk), .rst_n(rst_n), .start(start_wait),
    .run(state_q == ST_WAIT), .slow_code(cfg_rate_8b10b),
    .expire(deadline_hit)
  );

  lwn_arbiter #(.PRIO_W(PRIO_W)) u_arb (
    .own_prio(pend_p_q), .peer_prio(rx_prio),
    .own_downstream(cfg_is_downstream), .peer_wins(peer_wins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= WW'(MAX_LANES);
      pend_w_q   <= '0;
      pend_p_q   <= '0;
      tx_valid   <= 1'b0;
      tx_mtype   <= '0;
      tx_cmd     <= CMD_NONE;
      tx_prio    <= '0;
      tx_width   <= '0;
      tx_payload <= '0;
      done       <= 1'b0;
      result_ack <= 1'b0;
      timed_out  <= 1'b0;
      err_status <= 1'b0;
    end else begin
      tx_valid   <= 1'b0;
      tx_cmd     <= CMD_NONE;
      done       <= 1'b0;
      result_ack <= 1'b0;
      timed_out  <= 1'b0;

      unique case (state_q)
        ST_IDLE: begin
          if (rx_is_req) begin
            if (loc_req_valid) done <= 1'b1;   // partner served first
          end else if (loc_req_valid) begin
            if (loc_ok) begin
              tx_valid   <= 1'b1;
              tx_mtype   <= MTYPE_WIDTH;
              tx_cmd     <= CMD_REQ;
              tx_prio    <= loc_req_prio;
              tx_width   <= loc_req_width;
              tx_payload <= RSN_OK;
              pend_w_q   <= loc_req_width;
              pend_p_q   <= loc_req_prio;
              state_q    <= ST_WAIT;
            end else begin
              done <= 1'b1;
              if (reason_is_error(loc_reason)) err_status <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (rx_is_ack) begin
            cur_q      <= pend_w_q;
            done       <= 1'b1;
            result_ack <= 1'b1;
            err_status <= 1'b0;
            state_q    <= ST_IDLE;
          end else if (rx_is_nak) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rx_is_req) begin
            if (peer_wins) begin
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              tx_valid   <= 1'b1;
              tx_mtype   <= MTYPE_WIDTH;
              tx_cmd     <= CMD_NAK;
              tx_prio    <= pend_p_q;
              tx_width   <= cur_q;
              tx_payload <= RSN_COLL;
            end
          end else if (deadline_hit) begin
            done      <= 1'b1;
            timed_out <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase

      // Answer a partner request (idle, or collision lost)
      if (answer_now) begin
        tx_valid   <= 1'b1;
        tx_mtype   <= MTYPE_WIDTH;
        tx_prio    <= rx_prio;
        tx_payload <= rx_reason;
        if (rx_ok) begin
          tx_cmd     <= CMD_ACK;
          tx_width   <= rx_width;
          cur_q      <= rx_width;
          err_status <= 1'b0;
        end else begin
          tx_cmd   <= CMD_NAK;
          tx_width <= cur_q;
          if (reason_is_error(rx_reason)) err_status <= 1'b1;
        end
      end
    end
  end

  assign cur_width = cur_q;
  assign busy      = (state_q == ST_WAIT);
endmodule

// File: rtl/lwn_checker.sv
module lwn_checker
  import lwn_pkg::*;
#(
  parameter  int unsigned MAX_LANES  = 16,
  parameter  int unsigned CYC_PER_US = 100,
  localparam int unsigned WW         = $clog2(MAX_LANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 feat_en,
  input logic                 cfg_rate_8b10b,
  input logic                 rx_is_ack,
  input logic                 busy,
  input logic [WW-1:0]        cur_width,
  input logic                 tx_valid,
  input logic [1:0]           tx_cmd,
  input logic [PAYLOAD_W-1:0] tx_payload,
  input logic                 done,
  input logic                 result_ack,
  input logic                 timed_out
);
  localparam int unsigned KW = $clog2(4 * CYC_PER_US + 2);

  logic [KW-1:0] wait_cnt;
  logic [KW-1:0] lim;

  assign lim = KW'(deadline_cycles(cfg_rate_8b10b, CYC_PER_US));

  always_ff @(posedge clk) begin
    if (!rst_n)    wait_cnt <= '0;
    else if (busy) wait_cnt <= wait_cnt + KW'(1);
    else           wait_cnt <= '0;
  end

  assert_ack_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_cmd == CMD_ACK) |-> $past(feat_en));

  assert_width_change_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_width) |-> ((tx_valid && tx_cmd == CMD_ACK) || (done && result_ack)));

  assert_ack_from_partner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_ack) |-> $past(rx_is_ack && busy));

  assert_deadline_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wait_cnt < lim));

  assert_timeout_is_refusal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (done && !result_ack && !busy));

  assert_width_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    width_legal(16'(cur_width), MAX_LANES));

  assert_collision_keeps_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_cmd == CMD_NAK && tx_payload == RSN_COLL) |-> busy);
endmodule

bind lwidth_negotiator lwn_checker #(
  .MAX_LANES(MAX_LANES), .CYC_PER_US(CYC_PER_US)
) u_lwn_checker (
  .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .cfg_rate_8b10b(cfg_rate_8b10b),
  .rx_is_ack(rx_is_ack), .busy(busy), .cur_width(cur_width),
  .tx_valid(tx_valid), .tx_cmd(tx_cmd), .tx_payload(tx_payload),
  .done(done), .result_ack(result_ack), .timed_out(timed_out)
);

// File: tb/tb_lwidth_negotiator.sv
module tb_lwidth_negotiator;
  localparam int unsigned LANES = 16;
  localparam int unsigned CYC   = 20;
  localparam int unsigned WW    = $clog2(LANES + 1);
  localparam logic [3:0] MT = 4'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_flit_mode = 0, cfg_local_support = 0, cfg_partner_support = 0;
  logic cfg_rate_8b10b = 0, cfg_is_downstream = 0;
  logic loc_req_valid = 0; logic [WW-1:0] loc_req_width = '0; logic [1:0] loc_req_prio = '0;
  logic rx_valid = 0; logic [3:0] rx_mtype = '0; logic [1:0] rx_cmd = '0;
  logic [1:0] rx_prio = '0; logic [WW-1:0] rx_width = '0;
  logic tx_valid; logic [3:0] tx_mtype; logic [1:0] tx_cmd; logic [1:0] tx_prio;
  logic [WW-1:0] tx_width; logic [7:0] tx_payload; logic [WW-1:0] cur_width;
  logic busy, done, result_ack, timed_out, err_status;

  int n_chk = 0, n_fail = 0;
  int exp_cur = LANES;
  bit exp_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lwidth_negotiator #(.MAX_LANES(LANES), .CYC_PER_US(CYC), .PRIO_W(2)) dut (.*);

  function automatic bit legal(input int w);
    return (w > 0) && (w <= LANES) && ((w & (w - 1)) == 0);
  endfunction

  function automatic int limit_of(input bit slow);
    return slow ? 4 * CYC : CYC;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_rx(input logic [3:0] mt, input logic [1:0] cmd,
                         input int pr, input int w);
    @(negedge clk);
    rx_valid = 1; rx_mtype = mt; rx_cmd = cmd; rx_prio = 2'(pr); rx_width = WW'(w);
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic send_loc(input int w, input int pr);
    @(negedge clk);
    loc_req_valid = 1; loc_req_width = WW'(w); loc_req_prio = 2'(pr);
    @(posedge clk); #1;
    loc_req_valid = 0;
  endtask

  // Partner request predicted from the requirements (R1, R2, R5)
  task automatic peer_req_check(input string req, input int w, input int pr);
    bit en;
    int rsn;
    en = cfg_flit_mode && cfg_local_support && cfg_partner_support;
    send_rx(MT, 2'd1, pr, w);
    if (!en) rsn = 1;
    else if (!legal(w)) rsn = 2;
    else if (w == exp_cur) rsn = 3;
    else rsn = 0;
    chk(req, "tx_valid", tx_valid, 1);
    chk(req, "tx_cmd", tx_cmd, rsn == 0 ? 2 : 3);
    chk(req, "tx_payload", tx_payload, rsn);
    chk(req, "tx_prio", tx_prio, pr);
    if (rsn == 0) begin exp_cur = w; exp_err = 0; end
    else if (rsn >= 2) exp_err = 1;
    chk(req, "cur_width", cur_width, exp_cur);
    chk(req, "err_status", err_status, exp_err);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    // R9 reset state
    chk("R9", "cur_width", cur_width, LANES);
    chk("R9", "busy", busy, 0);
    chk("R9", "tx_valid", tx_valid, 0);
    chk("R9", "err_status", err_status, 0);

    // R1 disabled: flit mode off
    cfg_local_support = 1; cfg_partner_support = 1;
    peer_req_check("R1", 8, 0);
    send_loc(8, 0);
    chk("R1", "done", done, 1);
    chk("R1", "result_ack", result_ack, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "err_status", err_status, 0);

    cfg_flit_mode = 1;
    // R2 partner request accepted
    peer_req_check("R2", 8, 1);
    chk("R2", "tx_width", tx_width, 8);

    // R5 illegal and redundant widths
    peer_req_check("R5", 8, 0);
    peer_req_check("R5", 0, 0);
    peer_req_check("R5", 3, 2);
    peer_req_check("R5", 24, 0);
    peer_req_check("R5", 2, 0);
    send_loc(6, 0);
    chk("R5", "done", done, 1);
    chk("R5", "tx_valid", tx_valid, 0);
    chk("R5", "err_status", err_status, 1);
    exp_err = 1;

    // R3 local request, ACK then NAK
    send_loc(4, 1);
    chk("R3", "tx_cmd", tx_cmd, 1);
    chk("R3", "tx_width", tx_width, 4);
    chk("R3", "tx_prio", tx_prio, 1);
    chk("R3", "busy", busy, 1);
    repeat (2) @(posedge clk);
    send_rx(MT, 2'd2, 0, 4);
    exp_cur = 4; exp_err = 0;
    chk("R3", "done", done, 1);
    chk("R3", "result_ack", result_ack, 1);
    chk("R3", "cur_width", cur_width, 4);
    chk("R3", "err_status", err_status, 0);
    send_loc(16, 0);
    send_rx(MT, 2'd3, 0, 16);
    chk("R3", "done", done, 1);
    chk("R3", "result_ack", result_ack, 0);
    chk("R3", "cur_width", cur_width, 4);

    // R7 foreign type and stray ACK are ignored
    send_rx(4'd3, 2'd1, 0, 8);
    chk("R7", "tx_valid", tx_valid, 0);
    chk("R7", "cur_width", cur_width, 4);
    send_rx(MT, 2'd2, 0, 2);
    chk("R7", "tx_valid", tx_valid, 0);
    chk("R7", "done", done, 0);
    chk("R7", "cur_width", cur_width, 4);

    // R8 local request while busy ignored
    send_loc(2, 0);
    send_loc(8, 0);
    chk("R8", "tx_valid", tx_valid, 0);
    chk("R8", "busy", busy, 1);
    send_rx(MT, 2'd2, 0, 2);
    exp_cur = 2;
    chk("R8", "cur_width", cur_width, 2);
    // R8 same-cycle local and partner request
    @(negedge clk);
    loc_req_valid = 1; loc_req_width = WW'(8); loc_req_prio = 2'd3;
    rx_valid = 1; rx_mtype = MT; rx_cmd = 2'd1; rx_prio = 2'd0; rx_width = WW'(16);
    @(posedge clk); #1;
    loc_req_valid = 0; rx_valid = 0;
    exp_cur = 16;
    chk("R8", "tx_cmd", tx_cmd, 2);
    chk("R8", "done", done, 1);
    chk("R8", "result_ack", result_ack, 0);
    chk("R8", "busy", busy, 0);
    chk("R8", "cur_width", cur_width, 16);

    // R4 timeout in the short window
    cfg_rate_8b10b = 0;
    send_loc(8, 0);
    repeat (limit_of(0) - 1) @(posedge clk);
    #1;
    chk("R4", "busy before deadline", busy, 1);
    chk("R4", "done before deadline", done, 0);
    @(posedge clk); #1;
    chk("R4", "done", done, 1);
    chk("R4", "timed_out", timed_out, 1);
    chk("R4", "result_ack", result_ack, 0);
    chk("R4", "busy", busy, 0);
    chk("R4", "cur_width", cur_width, 16);
    // R4 answer on the last allowed edge of the long window
    cfg_rate_8b10b = 1;
    send_loc(4, 0);
    repeat (limit_of(1) - 1) @(posedge clk);
    send_rx(MT, 2'd2, 0, 4);
    exp_cur = 4;
    chk("R4", "late ack done", done, 1);
    chk("R4", "late ack result", result_ack, 1);
    chk("R4", "late ack timed_out", timed_out, 0);
    chk("R4", "cur_width", cur_width, 4);
    cfg_rate_8b10b = 0;

    // R6 collisions
    cfg_is_downstream = 0;
    send_loc(8, 1);
    send_rx(MT, 2'd1, 2, 2);
    exp_cur = 2;
    chk("R6", "higher peer tx_cmd", tx_cmd, 2);
    chk("R6", "higher peer done", done, 1);
    chk("R6", "higher peer result", result_ack, 0);
    chk("R6", "cur_width", cur_width, 2);
    cfg_is_downstream = 1;
    send_loc(8, 1);
    send_rx(MT, 2'd1, 1, 4);
    chk("R6", "tie won tx_cmd", tx_cmd, 3);
    chk("R6", "tie won payload", tx_payload, 4);
    chk("R6", "tie won busy", busy, 1);
    chk("R6", "cur_width", cur_width, 2);
    send_rx(MT, 2'd2, 0, 8);
    exp_cur = 8;
    chk("R6", "after win cur_width", cur_width, 8);
    cfg_is_downstream = 0;
    send_loc(4, 1);
    send_rx(MT, 2'd1, 1, 16);
    exp_cur = 16;
    chk("R6", "tie lost tx_cmd", tx_cmd, 2);
    chk("R6", "tie lost done", done, 1);
    chk("R6", "cur_width", cur_width, 16);
    cfg_is_downstream = 1;
    send_loc(8, 2);
    send_rx(MT, 2'd1, 3, 2);
    exp_cur = 2;
    chk("R6", "prio beats role", tx_cmd, 2);
    chk("R6", "cur_width", cur_width, 2);

    // Random mix (R1, R2, R3, R5)
    for (int i = 0; i < 150; i++) begin
      int w, pr, op;
      bit en;
      @(negedge clk);
      cfg_flit_mode = ($urandom % 8) != 0;
      cfg_partner_support = ($urandom % 8) != 0;
      en = cfg_flit_mode && cfg_local_support && cfg_partner_support;
      w = $urandom % 20; pr = $urandom % 4; op = $urandom % 2;
      if ($urandom % 2) w = 1 << ($urandom % 5);
      if (op == 0) begin
        peer_req_check("R2", w, pr);
      end else begin
        send_loc(w, pr);
        if (en && legal(w) && w != exp_cur) begin
          bit take;
          chk("R3", "tx_cmd", tx_cmd, 1);
          take = $urandom % 2;
          repeat ($urandom % 4) @(posedge clk);
          send_rx(MT, take ? 2'd2 : 2'd3, 0, w);
          if (take) begin exp_cur = w; exp_err = 0; end
          chk("R3", "result_ack", result_ack, take);
        end else begin
          if (en) exp_err = 1;
          chk("R1", "refused tx_valid", tx_valid, 0);
          chk("R5", "refused err", err_status, exp_err);
        end
        chk("R3", "done", done, 1);
        chk("R3", "cur_width", cur_width, exp_cur);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule